// File: doc/BRIEF.md
# Serial Display Frame Loader

This controller sits on the host side of a display path. It converts a parallel frame word into the serial stream expected by an external shift-and-latch display driver with a chain of `NBITS` stages. A single-cycle `start_i` pulse captures the frame word and a shift direction. The block then drives serial data and a shift clock one bit at a time, waits out a gap, and raises a latch strobe so that the driver copies its chain into its output latch. Each interface timing minimum is a parameter in nanoseconds. The block converts each one into a whole number of system-clock cycles, rounding up.

After reset the block holds the driver's clear line low, which blanks the display. It shifts `NBITS` zero bits into the chain and strobes them into the latch. Only then does it release the clear line, so the display never shows the random contents the driver holds at power-up. While the block is running, a separate blank request can force the clear line low for a fixed hold time. This request does not disturb a transfer that is already in progress.

Top module: `dfl_frame_loader`

## Requirements
- R1: Reset behaviour and flush.
  - While reset is held, `clear_o` is low, `busy_o` is high, and `sclk_o`, `stb_o` and `done_o` are low.
  - After reset, the block shifts `NBITS` bits of 0 and strobes them.
  - `clear_o` stays low for the whole of that flush, which lasts FRAME = `NBITS*(LO_CYC+HI_CYC)+GAP_CYC+STB_CYC` cycles.
  - `clear_o` rises in the same cycle that `busy_o` falls.
  - The flush produces no `done_o` pulse.
- R2: Serial data setup and hold.
  - `sdata_o` changes no later than ceil(SETUP_NS/CLK_NS) cycles before each rising edge of `sclk_o`.
  - `sdata_o` then stays unchanged for at least ceil(HOLD_NS/CLK_NS) cycles after that rising edge.
- R3: Shift clock widths.
  - `sclk_o` stays low for at least LO_CYC cycles, where LO_CYC = max(ceil(SCLK_LO_NS/CLK_NS), ceil(SETUP_NS/CLK_NS)).
  - `sclk_o` stays high for at least HI_CYC cycles, where HI_CYC = max(ceil(SCLK_HI_NS/CLK_NS), ceil(HOLD_NS/CLK_NS), ceil(SCLK_PER_NS/CLK_NS) - LO_CYC).
  - Consecutive rising edges of `sclk_o` are at least ceil(SCLK_PER_NS/CLK_NS) cycles apart.
- R4: Latch strobe timing.
  - `stb_o` rises at least GAP_CYC = ceil(GAP_NS/CLK_NS) cycles after the last falling edge of `sclk_o`.
  - `stb_o` stays high for at least STB_CYC = ceil(STB_NS/CLK_NS) cycles.
  - `sclk_o` is low whenever `stb_o` is high.
- R5: Bit order and direction.
  - `sdir_o` is 1 when the driver shifts from stage 1 toward stage `NBITS`, and 0 for the opposite direction.
  - `sdir_o` holds, for the whole transfer, the `dir_i` value captured at start.
  - With `sdir_o`=1 the block sends `frame_i` bit `NBITS-1` first. With `sdir_o`=0 it sends bit 0 first.
  - Each transfer has exactly `NBITS` rising edges of `sclk_o`. Afterwards driver stage i+1 holds frame bit i.
- R6: Busy and done.
  - When a start pulse is accepted in idle, `busy_o` is high from the next cycle for exactly FRAME cycles.
  - `done_o` is then high for one cycle, which is the first cycle with `busy_o` low.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The transfer in progress completes with its original frame and direction, only one done pulse follows, and no new transfer begins.
- R8: Blank request.
  - A one-cycle `blank_i` pulse drives `clear_o` low for exactly BLANK_CYC = ceil(BLANK_NS/CLK_NS) cycles, starting the next cycle. This applies in idle and during a transfer.
  - A transfer that overlaps the blank keeps the timing of R6 and the contents of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to load a frame |
| frame_i | input | NBITS | Frame word, bit i destined for driver stage i+1 |
| dir_i | input | 1 | Shift direction captured with the start pulse |
| blank_i | input | 1 | One-cycle request to blank the display |
| sdata_o | output | 1 | Serial data to the driver |
| sclk_o | output | 1 | Shift clock to the driver, data sampled on its rising edge |
| sdir_o | output | 1 | Shift direction to the driver |
| stb_o | output | 1 | Latch strobe to the driver, active high |
| clear_o | output | 1 | Driver clear, active low, blanks all outputs |
| busy_o | output | 1 | Transfer or flush in progress |
| done_o | output | 1 | One-cycle pulse when a frame transfer has been latched |

## Verification
The assertions assume the following about the inputs:
- `start_i` and `blank_i` are synchronous to `clk`.
- `frame_i` and `dir_i` are valid in the cycle in which `start_i` is high.
- The external driver samples `sdata_o` on the rising edge of `sclk_o`.

The bench drives every input on the falling edge of the system clock. It holds each request pulse for exactly one cycle. It models the driver as an `NBITS`-stage chain that shifts in the direction given by `sdir_o` and copies into a latch while `stb_o` is high. Timing minima are measured on the falling edges of the system clock. Extra start pulses are sent only in the middle of a transfer.

// File: rtl/dfl_pkg.sv
package dfl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_STROBE
    } dfl_state_e;

    typedef struct packed {
        dfl_state_e state;
        logic       flush;
        logic       done;
    } dfl_ctl_t;

    function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dfl_phase_timer.sv
module dfl_phase_timer #(
    parameter int unsigned W       = 5,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= W'(RST_VAL);
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R3: once expired, the phase timer stays expired until reloaded
    p_expire_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !load_i) |=> expired_o);

endmodule

// File: rtl/dfl_bit_shifter.sv
module dfl_bit_shifter #(
    parameter int unsigned NBITS = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [NBITS-1:0] frame_i,
    input  logic             dir_i,
    input  logic             step_i,
    output logic             bit_o,
    output logic             dir_o,
    output logic             last_o
);
    localparam int unsigned CW = $clog2(NBITS + 1);

    typedef struct packed {
        logic [NBITS-1:0] data;
        logic [CW-1:0]    left;
        logic             dir;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.data = frame_i;
            sh_d.left = CW'(NBITS);
            sh_d.dir  = dir_i;
        end else if (step_i) begin
            sh_d.data = sh_q.dir ? {sh_q.data[NBITS-2:0], 1'b0}
                                 : {1'b0, sh_q.data[NBITS-1:1]};
            sh_d.left = sh_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q.data <= '0;
            sh_q.left <= CW'(NBITS);
            sh_q.dir  <= 1'b1;
        end else begin
            sh_q <= sh_d;
        end
    end

    // far-end bit leaves first: top bit when shifting upward, bottom bit otherwise
    assign bit_o  = sh_q.dir ? sh_q.data[NBITS-1] : sh_q.data[0];
    assign dir_o  = sh_q.dir;
    assign last_o = (sh_q.left == CW'(1));

    // R5: the sequencer never advances past the final bit of a frame
    p_no_step_past_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> !last_o);

    // R5: remaining-bit count stays within 1..NBITS
    p_left_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.left != '0) && (sh_q.left <= CW'(NBITS)));

endmodule

// File: rtl/dfl_blank_ctl.sv
module dfl_blank_ctl #(
    parameter int unsigned HOLD_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic active_o
);
    localparam int unsigned W = $clog2(HOLD_CYC + 1);

    logic [W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (req_i) begin
            hold_d = W'(HOLD_CYC);
        end else if (hold_q != '0) begin
            hold_d = hold_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign active_o = (hold_q != '0);

    // R8: a request takes effect on the following cycle
    p_blank_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> active_o);

endmodule

// File: rtl/dfl_frame_loader.sv
module dfl_frame_loader
    import dfl_pkg::*;
#(
    parameter int unsigned NBITS       = 40,
    parameter int unsigned CLK_NS      = 10,
    parameter int unsigned SETUP_NS    = 50,
    parameter int unsigned HOLD_NS     = 50,
    parameter int unsigned SCLK_HI_NS  = 75,
    parameter int unsigned SCLK_LO_NS  = 75,
    parameter int unsigned SCLK_PER_NS = 250,
    parameter int unsigned GAP_NS      = 50,
    parameter int unsigned STB_NS      = 80,
    parameter int unsigned BLANK_NS    = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NBITS-1:0] frame_i,
    input  logic             dir_i,
    input  logic             blank_i,
    output logic             sdata_o,
    output logic             sclk_o,
    output logic             sdir_o,
    output logic             stb_o,
    output logic             clear_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam int unsigned LO_CYC    = umax(1, umax(cdiv(SCLK_LO_NS, CLK_NS), cdiv(SETUP_NS, CLK_NS)));
    localparam int unsigned PER_CYC   = cdiv(SCLK_PER_NS, CLK_NS);
    localparam int unsigned HI_MIN    = umax(1, umax(cdiv(SCLK_HI_NS, CLK_NS), cdiv(HOLD_NS, CLK_NS)));
    localparam int unsigned HI_CYC    = umax(HI_MIN, (PER_CYC > LO_CYC) ? (PER_CYC - LO_CYC) : 0);
    localparam int unsigned GAP_CYC   = umax(1, cdiv(GAP_NS, CLK_NS));
    localparam int unsigned STB_CYC   = umax(1, cdiv(STB_NS, CLK_NS));
    localparam int unsigned BLANK_CYC = umax(1, cdiv(BLANK_NS, CLK_NS));
    localparam int unsigned TMAX      = umax(umax(LO_CYC, HI_CYC), umax(GAP_CYC, STB_CYC));
    localparam int unsigned TW        = (TMAX > 1) ? $clog2(TMAX) : 1;

    dfl_ctl_t        ctl_d, ctl_q;
    logic            tmr_load;
    logic [TW-1:0]   tmr_val;
    logic            tmr_done;
    logic            sh_load, sh_step, sh_last, sh_bit, sh_dir;
    logic            blank_act;

    dfl_phase_timer #(.W(TW), .RST_VAL(LO_CYC - 1)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_done)
    );

    dfl_bit_shifter #(.NBITS(NBITS)) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .frame_i (frame_i),
        .dir_i   (dir_i),
        .step_i  (sh_step),
        .bit_o   (sh_bit),
        .dir_o   (sh_dir),
        .last_o  (sh_last)
    );

    dfl_blank_ctl #(.HOLD_CYC(BLANK_CYC)) u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (blank_i),
        .active_o (blank_act)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        sh_load    = 1'b0;
        sh_step    = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    sh_load     = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = TW'(LO_CYC - 1);
                    ctl_d.state = ST_LOW;
                end
            end
            ST_LOW: begin
                if (tmr_done) begin
                    tmr_load    = 1'b1;
                    tmr_val     = TW'(HI_CYC - 1);
                    ctl_d.state = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (sh_last) begin
                        tmr_val     = TW'(GAP_CYC - 1);
                        ctl_d.state = ST_GAP;
                    end else begin
                        sh_step     = 1'b1;
                        tmr_val     = TW'(LO_CYC - 1);
                        ctl_d.state = ST_LOW;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_done) begin
                    tmr_load    = 1'b1;
                    tmr_val     = TW'(STB_CYC - 1);
                    ctl_d.state = ST_STROBE;
                end
            end
            ST_STROBE: begin
                if (tmr_done) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.flush = 1'b0;
                    ctl_d.done  = !ctl_q.flush;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_LOW;
            ctl_q.flush <= 1'b1;
            ctl_q.done  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sdata_o = sh_bit;
    assign sdir_o  = sh_dir;
    assign sclk_o  = (ctl_q.state == ST_HIGH);
    assign stb_o   = (ctl_q.state == ST_STROBE);
    assign busy_o  = (ctl_q.state != ST_IDLE);
    assign done_o  = ctl_q.done;
    assign clear_o = !(ctl_q.flush || blank_act);

    // R1: the display stays blanked for the whole post-reset flush
    p_flush_blanked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.flush |-> !clear_o);

    // R2: serial data does not move while the shift clock is high
    p_data_stable_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

    // R4: strobe and shift clock are never high together
    p_strobe_clk_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> !sclk_o);

    // R5: direction is frozen for the length of a transfer
    p_dir_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(sdir_o));

    // R6: done appears only in the first idle cycle after a transfer
    p_done_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R6: a completed strobe always returns the block to idle
    p_strobe_end_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stb_o) |-> !busy_o);

endmodule

// File: tb/tb_dfl_frame_loader.sv
module tb_dfl_frame_loader;
    localparam int CLK_PERIOD = 10;
    localparam int NB         = 40;
    localparam int CLK_NS     = 10;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int SETUP_C   = cdiv(50, CLK_NS);
    localparam int HOLD_C    = cdiv(50, CLK_NS);
    localparam int PER_C     = cdiv(250, CLK_NS);
    localparam int LO_C      = imax(cdiv(75, CLK_NS), SETUP_C);
    localparam int HI_C      = imax(imax(cdiv(75, CLK_NS), HOLD_C), PER_C - LO_C);
    localparam int GAP_C     = cdiv(50, CLK_NS);
    localparam int STB_C     = cdiv(80, CLK_NS);
    localparam int BLANK_C   = cdiv(2000, CLK_NS);
    localparam int FRAME_C   = NB * (LO_C + HI_C) + GAP_C + STB_C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NB-1:0] frame = '0;
    logic          dir = 1'b1;
    logic          blank = 1'b0;
    logic          sdata, sclk, sdir, stb, clear, busy, done;

    dfl_frame_loader #(
        .NBITS(NB), .CLK_NS(CLK_NS), .SETUP_NS(50), .HOLD_NS(50),
        .SCLK_HI_NS(75), .SCLK_LO_NS(75), .SCLK_PER_NS(250),
        .GAP_NS(50), .STB_NS(80), .BLANK_NS(2000)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .frame_i(frame), .dir_i(dir),
        .blank_i(blank), .sdata_o(sdata), .sclk_o(sclk), .sdir_o(sdir), .stb_o(stb),
        .clear_o(clear), .busy_o(busy), .done_o(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // driver model and timing monitor, sampled on falling edges
    int busy_cnt = 0, done_cnt = 0, rise_cnt = 0, clr_cnt = 0;
    int v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r6 = 0;
    int since_data = 1000, since_rise = 1000, since_fall = 1000, stb_len = 0;
    logic prev_s = 1'b0, prev_d = 1'b0, prev_b = 1'b0, prev_busy = 1'b1;
    logic [NB-1:0] drv = '1;
    logic [NB-1:0] lat = '1;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_s = 1'b0; prev_d = sdata; prev_b = 1'b0; prev_busy = 1'b1;
        end else begin
            since_data++; since_rise++; since_fall++;
            if (busy) busy_cnt++;
            if (done) begin
                done_cnt++;
                if (busy || !prev_busy) v_r6++;
            end
            if (!clear) clr_cnt++;
            if (sdata !== prev_d) begin
                if (since_rise < HOLD_C) v_r2++;
                since_data = 0;
            end
            if (sclk && !prev_s) begin
                if (since_data < SETUP_C) v_r2++;
                if (since_rise < PER_C) v_r3++;
                if (since_fall < LO_C) v_r3++;
                since_rise = 0;
                rise_cnt++;
                drv = sdir ? {drv[NB-2:0], sdata} : {sdata, drv[NB-1:1]};
            end
            if (!sclk && prev_s) begin
                if (since_rise < HI_C) v_r3++;
                since_fall = 0;
            end
            if (stb && !prev_b) begin
                if (since_fall < GAP_C) v_r4++;
                stb_len = 0;
            end
            if (stb) begin
                stb_len++;
                lat = drv;
                if (sclk) v_r4++;
            end
            if (!stb && prev_b && stb_len < STB_C) v_r4++;
            prev_s = sclk; prev_d = sdata; prev_b = stb; prev_busy = busy;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R6 watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic run_frame(input logic [NB-1:0] f, input logic d,
                             input int blank_at, input int intrude_at);
        int b0, d0, r0, c0, e2, e3, e4, e6;
        bit seen;
        @(posedge clk);
        b0 = busy_cnt; d0 = done_cnt; r0 = rise_cnt; c0 = clr_cnt;
        e2 = v_r2; e3 = v_r3; e4 = v_r4; e6 = v_r6;
        @(negedge clk);
        frame = f; dir = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < FRAME_C + 50 && !seen; k++) begin
            blank = (k == blank_at);
            if (k == intrude_at) begin
                start = 1'b1; frame = ~f; dir = ~d;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            if (done_cnt != d0) seen = 1'b1;
            @(negedge clk);
        end
        blank = 1'b0; start = 1'b0;
        repeat ((blank_at >= 0) ? BLANK_C + 20 : 5) @(negedge clk);
        @(posedge clk);
        check(seen, "R6 done seen", longint'(seen), 1);
        check(busy_cnt - b0 == FRAME_C, "R6 busy length", busy_cnt - b0, FRAME_C);
        check(done_cnt - d0 == 1, "R6 done pulses", done_cnt - d0, 1);
        check(v_r6 == e6, "R6 done placement", v_r6 - e6, 0);
        check(rise_cnt - r0 == NB, "R5 rising edges", rise_cnt - r0, NB);
        check(lat == f, "R5 latched frame", longint'(lat), longint'(f));
        check(clr_cnt - c0 == ((blank_at >= 0) ? BLANK_C : 0), "R8 clear low cycles",
              clr_cnt - c0, (blank_at >= 0) ? BLANK_C : 0);
        check(v_r2 == e2, "R2 setup/hold", v_r2 - e2, 0);
        check(v_r3 == e3, "R3 clock widths", v_r3 - e3, 0);
        check(v_r4 == e4, "R4 strobe timing", v_r4 - e4, 0);
        check(!busy && clear, "R7 idle after transfer", {busy, clear}, 2'b01);
    endtask

    initial begin
        int c0;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!clear && busy && !sclk && !stb && !done, "R1 reset outputs",
              {clear, busy, sclk, stb, done}, 5'b01000);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: flush completes with display blanked
        for (int k = 0; k < FRAME_C + 100 && busy; k++) @(posedge clk);
        check(busy_cnt == FRAME_C, "R1 flush length", busy_cnt, FRAME_C);
        check(clr_cnt == FRAME_C, "R1 clear low during flush", clr_cnt, FRAME_C);
        check(clear, "R1 clear released", longint'(clear), 1);
        check(rise_cnt == NB, "R1 flush shifts", rise_cnt, NB);
        check(drv == '0 && lat == '0, "R1 driver zeroed", longint'(lat), 0);
        check(done_cnt == 0, "R1 no done on flush", done_cnt, 0);
        check(v_r2 == 0 && v_r3 == 0 && v_r4 == 0, "R2 R3 R4 flush timing",
              v_r2 + v_r3 + v_r4, 0);

        // R5: patterns in both directions
        run_frame('1, 1'b1, -1, -1);
        run_frame('1, 1'b0, -1, -1);
        run_frame(40'hAA_AAAA_AAAA, 1'b1, -1, -1);
        run_frame(40'hAA_AAAA_AAAA, 1'b0, -1, -1);
        run_frame(40'h12_3456_789A, 1'b1, -1, -1);
        run_frame(40'h12_3456_789A, 1'b0, -1, -1);
        run_frame('0, 1'b1, -1, -1);

        // R7: start while busy is ignored
        run_frame(40'hC3_0F5A_9E61, 1'b1, -1, 300);
        run_frame(40'h81_7E00_FF18, 1'b0, -1, FRAME_C - 20);

        // R8: blank during a transfer
        run_frame(40'h5A_5A5A_5A5A, 1'b1, 400, -1);

        // R8: blank in idle
        @(posedge clk);
        c0 = clr_cnt;
        @(negedge clk); blank = 1'b1;
        @(negedge clk); blank = 1'b0;
        check(!clear, "R8 idle blank active", longint'(clear), 0);
        repeat (BLANK_C + 10) @(negedge clk);
        @(posedge clk);
        check(clr_cnt - c0 == BLANK_C, "R8 idle blank length", clr_cnt - c0, BLANK_C);
        check(clear && !busy, "R8 idle blank released", {clear, busy}, 2'b10);

        // R5: one-hot sweep over every position, both directions
        for (int dd = 0; dd < 2; dd++) begin
            for (int p = 0; p < NB; p++) begin
                run_frame(NB'(1) << p, dd[0], -1, -1);
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule